// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral holds a 512-word local buffer and moves a block of 32-bit words between that buffer and a configuration port, in either direction. A host bus reaches the buffer one word at a time and also reaches four control registers. These registers hold the transfer length in bytes, the first buffer word of the transfer, a direction register whose write launches the transfer, and a combined status word.

In configure mode the engine reads consecutive buffer words and offers them on the port. It offers one word per cycle while the port is not busy, and the buffer read runs one cycle ahead. In readback mode the engine raises its read request and stores each word the port marks valid at the next buffer address. Buffer addresses wrap modulo the buffer depth. A host write to the status address aborts a running transfer at once.

Top module: `cfgbuf_xfer`

## Requirements
- R1: The host reads and writes buffer word N at byte address N*4 (0x000..0x7FC). Read data appears on `hst_rdata` in the cycle after the request. Misaligned addresses are ignored.
- R2: After reset the size register (0x800) and the offset register (0x804) read 0. Both read back the last value written. The direction register (0x808) reads 0, and both port strobes are low.
- R3: Writing 0 to 0x808 while idle starts a configure transfer. It sends size/4 words (size bits 1:0 are ignored) from the buffer, starting at the offset word, in address order on `cp_wdata`. A word is taken in a cycle where `cp_wr_en` is high and `cp_busy` is low. While `cp_busy` is high, `cp_wr_en` and `cp_wdata` hold.
- R4: Writing 1 to 0x808 while idle starts a readback transfer. `cp_rd_en` stays high until size/4 words have been taken. Each cycle with `cp_rvalid` high stores `cp_rdata` at the next buffer word. `cp_wr_en` and `cp_rd_en` are never high together.
- R5: Status bit 0 (done) reads 0 while a transfer runs and 1 when idle, including after the last word.
- R6: In the status word (0x80C) bits 4:1 read 1111. Bit 5 shows `cp_abort_n`, bit 6 `cp_rb_active`, bit 7 `cp_aligned` and bit 8 `cp_cfg_err`. Bits 31:9 read 0.
- R7: Any write to 0x80C stops a running transfer. In the next cycle both strobes are low and done is 1.
- R8: A write to 0x808 while a transfer runs has no effect on that transfer.
- R9: When the offset plus the word count exceeds 512, the buffer address wraps from word 511 to word 0.
- R10: A size below 4 bytes starts no transfer. Done stays 1 and neither strobe rises.
- R11: In configure mode with `cp_busy` low, the words leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 12 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after a read |
| cp_wr_en | output | 1 | Configure word offered on the port |
| cp_wdata | output | 32 | Configure word |
| cp_busy | input | 1 | Port cannot take a word this cycle |
| cp_rd_en | output | 1 | Readback requested |
| cp_rdata | input | 32 | Readback word |
| cp_rvalid | input | 1 | Readback word valid |
| cp_abort_n | input | 1 | Port abort flag, active low |
| cp_rb_active | input | 1 | Port readback-in-progress flag |
| cp_aligned | input | 1 | Port synchronization-aligned flag |
| cp_cfg_err | input | 1 | Port configuration-error flag |

## Verification
The hardest situations to reach are a direction write or a status write that lands while a transfer is still running. A transfer normally ends within a few cycles of its start. The bench holds the port stub's busy line high so that a configure transfer stalls. It then issues the second direction write or the abort, then releases busy and compares the words the stub collected. Random offsets near the top of the buffer and random busy and valid patterns cover wrap-around and pipeline stalls in both directions.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_CFG  = 2'd1,
        ENG_RB   = 2'd2
    } eng_state_e;

    // register index decoded from byte address bits 3:2
    localparam logic [1:0] REG_SIZE   = 2'd0;
    localparam logic [1:0] REG_OFFSET = 2'd1;
    localparam logic [1:0] REG_DIR    = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;

    // status word bit positions
    localparam int ST_DONE    = 0;
    localparam int ST_MARK_LO = 1;
    localparam int ST_ABORTN  = 5;
    localparam int ST_RBACT   = 6;
    localparam int ST_ALIGN   = 7;
    localparam int ST_CFGERR  = 8;

endpackage

// File: rtl/cfgbuf_ram.sv
module cfgbuf_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // read outputs hold their value while the port is not enabled for read
    always_ff @(posedge clk) begin
        if (a_en && a_we)  mem_q[a_addr] <= a_wdata;
        if (b_en && b_we)  mem_q[b_addr] <= b_wdata;
        if (a_en && !a_we) a_rdata <= mem_q[a_addr];
        if (b_en && !b_we) b_rdata <= mem_q[b_addr];
    end
endmodule

// File: rtl/cfgbuf_regs.sv
module cfgbuf_regs
    import cfgbuf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 9,
    parameter int HA_W = AW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_req,
    input  logic            hst_we,
    input  logic [HA_W-1:0] hst_addr,
    input  logic [DW-1:0]   hst_wdata,
    input  logic            eng_done,
    input  logic            cp_abort_n,
    input  logic            cp_rb_active,
    input  logic            cp_aligned,
    input  logic            cp_cfg_err,
    output logic            buf_en,
    output logic            buf_we,
    output logic [AW-1:0]   buf_addr,
    output logic [DW-3:0]   size_words,
    output logic [AW-1:0]   start_word,
    output logic            start,
    output logic            start_dir,
    output logic            abort,
    output logic            sel_buf,
    output logic [DW-1:0]   reg_rdata
);
    typedef struct packed {
        logic [DW-1:0] size;
        logic [DW-1:0] offset;
        logic [DW-1:0] rdata;
        logic          sel_buf;
    } regs_t;

    regs_t r_q, r_d;

    logic          aligned_hit;
    logic          is_buf;
    logic          reg_hit;
    logic [1:0]    idx;
    logic [DW-1:0] status_word;

    always_comb begin
        aligned_hit = hst_req && (hst_addr[1:0] == 2'b00);
        is_buf      = !hst_addr[HA_W-1];
        reg_hit     = aligned_hit && !is_buf && (hst_addr[HA_W-2:4] == '0);
        idx         = hst_addr[3:2];

        status_word                         = '0;
        status_word[ST_DONE]                = eng_done;
        status_word[ST_MARK_LO +: 4]        = 4'hF;
        status_word[ST_ABORTN]              = cp_abort_n;
        status_word[ST_RBACT]               = cp_rb_active;
        status_word[ST_ALIGN]               = cp_aligned;
        status_word[ST_CFGERR]              = cp_cfg_err;

        buf_en    = aligned_hit && is_buf;
        buf_we    = hst_we;
        buf_addr  = hst_addr[HA_W-2:2];
        start     = reg_hit && hst_we && (idx == REG_DIR);
        start_dir = hst_wdata[0];
        abort     = reg_hit && hst_we && (idx == REG_STATUS);

        r_d = r_q;
        if (reg_hit && hst_we) begin
            if (idx == REG_SIZE)   r_d.size   = hst_wdata;
            if (idx == REG_OFFSET) r_d.offset = hst_wdata;
        end
        if (aligned_hit && !hst_we) begin
            r_d.sel_buf = is_buf;
            r_d.rdata   = '0;
            if (reg_hit) begin
                case (idx)
                    REG_SIZE:   r_d.rdata = r_q.size;
                    REG_OFFSET: r_d.rdata = r_q.offset;
                    REG_DIR:    r_d.rdata = '0;
                    default:    r_d.rdata = status_word;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign size_words = r_q.size[DW-1:2];
    assign start_word = r_q.offset[AW-1:0];
    assign sel_buf    = r_q.sel_buf;
    assign reg_rdata  = r_q.rdata;

    // a status read returns the fixed marker bits and zero upper bits
    p_status_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && !hst_we && idx == REG_STATUS)
        |=> (reg_rdata[4:1] == 4'hF) && (reg_rdata[DW-1:9] == '0));

    // a size write is visible on the next size read
    p_size_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && hst_we && idx == REG_SIZE) |=> size_words == $past(hst_wdata[DW-1:2]));
endmodule

// File: rtl/cfgbuf_engine.sv
module cfgbuf_engine
    import cfgbuf_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 9,
    parameter int CW = DW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_dir,
    input  logic          abort,
    input  logic [CW-1:0] size_words,
    input  logic [AW-1:0] start_word,
    output logic          done,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          cp_wr_en,
    output logic [DW-1:0] cp_wdata,
    input  logic          cp_busy,
    output logic          cp_rd_en,
    input  logic [DW-1:0] cp_rdata,
    input  logic          cp_rvalid
);
    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] ptr;
        logic [CW-1:0] iss_left;
        logic [CW-1:0] xfer_left;
        logic          wvalid;
    } eng_t;

    eng_t r_q, r_d;
    logic issue;
    logic accept;

    always_comb begin
        r_d       = r_q;
        issue     = 1'b0;
        accept    = (r_q.state == ENG_CFG) && r_q.wvalid && !cp_busy;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ptr;
        mem_wdata = cp_rdata;

        case (r_q.state)
            ENG_IDLE: begin
                if (start && size_words != '0) begin
                    r_d.ptr       = start_word;
                    r_d.iss_left  = size_words;
                    r_d.xfer_left = size_words;
                    r_d.wvalid    = 1'b0;
                    r_d.state     = start_dir ? ENG_RB : ENG_CFG;
                end
            end
            ENG_CFG: begin
                issue = (r_q.iss_left != '0) && (!r_q.wvalid || accept);
                if (issue) begin
                    mem_en       = 1'b1;
                    r_d.ptr      = r_q.ptr + 1'b1;
                    r_d.iss_left = r_q.iss_left - 1'b1;
                end
                r_d.wvalid = issue ? 1'b1 : (accept ? 1'b0 : r_q.wvalid);
                if (accept) begin
                    r_d.xfer_left = r_q.xfer_left - 1'b1;
                    if (r_q.xfer_left == CW'(1)) begin
                        r_d.state  = ENG_IDLE;
                        r_d.wvalid = 1'b0;
                    end
                end
            end
            ENG_RB: begin
                if (cp_rvalid) begin
                    mem_en        = 1'b1;
                    mem_we        = 1'b1;
                    r_d.ptr       = r_q.ptr + 1'b1;
                    r_d.xfer_left = r_q.xfer_left - 1'b1;
                    if (r_q.xfer_left == CW'(1)) r_d.state = ENG_IDLE;
                end
            end
            default: r_d.state = ENG_IDLE;
        endcase

        if (abort) begin
            r_d.state     = ENG_IDLE;
            r_d.wvalid    = 1'b0;
            r_d.iss_left  = '0;
            r_d.xfer_left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ENG_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = (r_q.state == ENG_IDLE);
    assign cp_wr_en = (r_q.state == ENG_CFG) && r_q.wvalid;
    assign cp_wdata = mem_rdata;
    assign cp_rd_en = (r_q.state == ENG_RB);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_wr_en && cp_rd_en));

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr_en && cp_busy && !abort) |=> cp_wr_en && $stable(cp_wdata));

    p_abort_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> done && !cp_wr_en && !cp_rd_en);

    p_zero_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done && size_words == '0 && !abort) |=> done);

    p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done && size_words != '0 && !abort) |=> !done);

    p_rb_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cp_rd_en && !abort) |=> !cp_wr_en);
endmodule

// File: rtl/cfgbuf_xfer.sv
module cfgbuf_xfer
    import cfgbuf_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DEPTH   = 512,
    parameter int HOST_AW = $clog2(DEPTH) + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [DW-1:0]      hst_wdata,
    output logic [DW-1:0]      hst_rdata,
    output logic               cp_wr_en,
    output logic [DW-1:0]      cp_wdata,
    input  logic               cp_busy,
    output logic               cp_rd_en,
    input  logic [DW-1:0]      cp_rdata,
    input  logic               cp_rvalid,
    input  logic               cp_abort_n,
    input  logic               cp_rb_active,
    input  logic               cp_aligned,
    input  logic               cp_cfg_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = DW - 2;

    logic          a_en, a_we, b_en, b_we;
    logic [AW-1:0] a_addr, b_addr, start_word;
    logic [DW-1:0] a_rdata, b_rdata, b_wdata, reg_rdata;
    logic [CW-1:0] size_words;
    logic          start, start_dir, abort, done, sel_buf;

    cfgbuf_regs #(.DW(DW), .AW(AW), .HA_W(HOST_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .eng_done(done),
        .cp_abort_n(cp_abort_n), .cp_rb_active(cp_rb_active),
        .cp_aligned(cp_aligned), .cp_cfg_err(cp_cfg_err),
        .buf_en(a_en), .buf_we(a_we), .buf_addr(a_addr),
        .size_words(size_words), .start_word(start_word),
        .start(start), .start_dir(start_dir), .abort(abort),
        .sel_buf(sel_buf), .reg_rdata(reg_rdata)
    );

    cfgbuf_engine #(.DW(DW), .AW(AW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_dir(start_dir), .abort(abort),
        .size_words(size_words), .start_word(start_word),
        .done(done),
        .mem_en(b_en), .mem_we(b_we), .mem_addr(b_addr),
        .mem_wdata(b_wdata), .mem_rdata(b_rdata),
        .cp_wr_en(cp_wr_en), .cp_wdata(cp_wdata), .cp_busy(cp_busy),
        .cp_rd_en(cp_rd_en), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid)
    );

    cfgbuf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(hst_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    assign hst_rdata = sel_buf ? a_rdata : reg_rdata;
endmodule

// File: tb/cfgbuf_xfer_tb.sv
`timescale 1ns/1ps
module cfgbuf_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [11:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0, hst_rdata;
    logic        cp_wr_en, cp_rd_en;
    logic [31:0] cp_wdata;
    logic        cp_busy = 1'b0, cp_rvalid = 1'b0;
    logic [31:0] cp_rdata = '0;
    logic        cp_abort_n = 1'b0, cp_rb_active = 1'b0, cp_aligned = 1'b0, cp_cfg_err = 1'b0;

    cfgbuf_xfer u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] model [512];
    logic [31:0] rx [1024];
    int rx_n = 0, rb_idx = 0, cyc = 0, first_wr = -1, last_wr = -1;
    int busy_mode = 0, rv_mode = 0;
    bit saw_rd = 0, saw_wr = 0, finished = 0;

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // port stub and monitor
    always @(negedge clk) begin
        cyc++;
        if (cp_wr_en) saw_wr = 1;
        if (cp_rd_en) saw_rd = 1;
        if (cp_wr_en && !cp_busy) begin
            if (rx_n < 1024) rx[rx_n] = cp_wdata;
            if (first_wr < 0) first_wr = cyc;
            last_wr = cyc;
            rx_n++;
        end
        if (cp_rd_en && cp_rvalid) rb_idx++;
    end
    always @(posedge clk) begin
        #1;
        cp_busy   = (busy_mode == 1) ? 1'b1 : (busy_mode == 2) ? 1'($urandom % 2) : 1'b0;
        cp_rvalid = (rv_mode == 1) ? 1'b1 : (rv_mode == 2) ? 1'($urandom % 2) : 1'b0;
        cp_rdata  = pat(rb_idx);
    end

    task automatic hwr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        hst_req = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 0; hst_we = 0;
    endtask

    task automatic hrd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_req = 1; hst_we = 0; hst_addr = a;
        @(negedge clk);
        hst_req = 0;
        d = hst_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            hrd(12'h80C, s);
            if (s[0]) return;
        end
        check("R5 done timeout", 32'd0, 32'd1);
    endtask

    task automatic clear_mon();
        rx_n = 0; first_wr = -1; last_wr = -1; saw_rd = 0; saw_wr = 0; rb_idx = 0;
    endtask

    task automatic run_cfg(int off, int cnt, int bmode, string req);
        clear_mon();
        busy_mode = bmode;
        hwr(12'h800, 32'(cnt * 4));
        hwr(12'h804, 32'(off));
        hwr(12'h808, 32'd0);
        wait_done();
        busy_mode = 0;
        check({req, " word count"}, 32'(rx_n), 32'(cnt));
        for (int i = 0; i < cnt && i < 1024; i++)
            check({req, " word"}, rx[i], model[(off + i) % 512]);
    endtask

    task automatic run_rb(int off, int cnt, string req);
        logic [31:0] v;
        clear_mon();
        rv_mode = 2;
        hwr(12'h800, 32'(cnt * 4));
        hwr(12'h804, 32'(off));
        hwr(12'h808, 32'd1);
        wait_done();
        rv_mode = 0;
        check({req, " no write strobe"}, 32'(saw_wr), 32'd0);
        for (int i = 0; i < cnt; i++) begin
            model[(off + i) % 512] = pat(i);
            hrd(12'((((off + i) % 512)) * 4), v);
            check({req, " stored word"}, v, pat(i));
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        check("R2 wr strobe", 32'(cp_wr_en), 0);
        check("R2 rd strobe", 32'(cp_rd_en), 0);
        hrd(12'h800, v); check("R2 size reset", v, 0);
        hrd(12'h804, v); check("R2 offset reset", v, 0);
        hrd(12'h80C, v); check("R5 R6 status reset", v, 32'h1F);
        hwr(12'h800, 32'h0000_0123); hrd(12'h800, v); check("R2 size readback", v, 32'h123);
        hwr(12'h804, 32'h0000_01AB); hrd(12'h804, v); check("R2 offset readback", v, 32'h1AB);
        hrd(12'h808, v); check("R2 dir reads zero", v, 0);

        // R6 flag mapping
        for (int m = 0; m < 16; m++) begin
            {cp_cfg_err, cp_aligned, cp_rb_active, cp_abort_n} = 4'(m);
            hrd(12'h80C, v);
            check("R6 status flags", v, 32'h1F | (32'(m) << 5));
        end
        {cp_cfg_err, cp_aligned, cp_rb_active, cp_abort_n} = 4'b0001;

        // R1 buffer fill and readback
        for (int i = 0; i < 512; i++) begin
            model[i] = $urandom;
            hwr(12'(i * 4), model[i]);
        end
        for (int i = 0; i < 40; i++) begin
            int a = $urandom % 512;
            hrd(12'(a * 4), v);
            check("R1 buffer read", v, model[a]);
        end
        hwr(12'h012, 32'hDEAD_BEEF);            // misaligned, ignored
        hrd(12'h010, v); check("R1 misaligned ignored", v, model[4]);

        // R11 back-to-back words
        run_cfg(10, 8, 0, "R3 R11");
        check("R11 consecutive cycles", 32'(last_wr - first_wr + 1), 32'd8);

        // R3 random configure with busy stalls, R9 wrap
        for (int t = 0; t < 6; t++) run_cfg($urandom % 512, 1 + $urandom % 40, 2, "R3");
        run_cfg(500, 30, 2, "R9 R3 wrap");

        // R3 size low bits ignored: 13 bytes = 3 words
        clear_mon();
        hwr(12'h800, 32'd13); hwr(12'h804, 32'd7); hwr(12'h808, 32'd0);
        wait_done();
        check("R3 size truncation", 32'(rx_n), 32'd3);

        // R10 zero size
        clear_mon();
        hwr(12'h800, 32'd3); hwr(12'h808, 32'd0);
        hrd(12'h80C, v);
        check("R10 done stays", 32'(v[0]), 1);
        check("R10 no strobe", 32'(saw_wr | saw_rd), 0);

        // R5 busy flag, R8 second direction write ignored
        clear_mon();
        busy_mode = 1;
        hwr(12'h800, 32'd20); hwr(12'h804, 32'd100); hwr(12'h808, 32'd0);
        hrd(12'h80C, v);
        check("R5 done low while running", 32'(v[0]), 0);
        hwr(12'h808, 32'd1);
        busy_mode = 0;
        wait_done();
        check("R8 no readback started", 32'(saw_rd), 0);
        check("R8 word count", 32'(rx_n), 32'd5);
        for (int i = 0; i < 5; i++) check("R8 word", rx[i], model[100 + i]);

        // R7 abort
        clear_mon();
        busy_mode = 1;
        hwr(12'h800, 32'd40); hwr(12'h804, 32'd0); hwr(12'h808, 32'd0);
        @(negedge clk);
        check("R7 running before abort", 32'(cp_wr_en), 1);
        hwr(12'h80C, 32'h0000_FEFE);
        check("R7 wr strobe low", 32'(cp_wr_en), 0);
        busy_mode = 0;
        hrd(12'h80C, v);
        check("R7 done after abort", 32'(v[0]), 1);
        repeat (4) @(negedge clk);
        check("R7 nothing sent", 32'(rx_n), 0);

        // R4 readback, including wrap (R9)
        for (int t = 0; t < 4; t++) run_rb($urandom % 512, 1 + $urandom % 30, "R4");
        run_rb(505, 12, "R9 R4 wrap");
        @(negedge clk);
        check("R4 rd strobe idle", 32'(cp_rd_en), 0);

        // R7 abort during readback
        clear_mon();
        rv_mode = 0;
        hwr(12'h800, 32'd16); hwr(12'h808, 32'd1);
        check("R4 rd strobe up", 32'(cp_rd_en), 1);
        hwr(12'h80C, 32'd0);
        check("R7 rd strobe low", 32'(cp_rd_en), 0);

        report();
    end
endmodule